// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit converts the 5-bit mode field of a general operand into the place where that operand lives. A request is presented with a one-cycle `start` strobe. Along with it come two displacements, an optional index byte, the operand size, a read/write flag, a stack-select bit, and the current values of the eight general registers and the frame, stack, static-base, program-counter and link-base registers. The unit answers with a one-cycle `done` and a result. The result is one of four kinds: a register number, a memory address, an immediate marker, or an illegal-mode marker.

Most modes resolve in one cycle. Memory-relative and external modes need a 32-bit pointer from memory first. For these the unit raises a read request, holds it until it is acknowledged, and then adds the second displacement to the returned pointer. Top-of-stack mode moves the selected stack pointer by the operand size: it decrements before a write and increments after a read. The new stack pointer value is reported next to the address.

In scaled-index modes, the index byte supplies both the base mode and the index register. The low two bits of the mode code set the scale factor. The scaled index is added to whatever address the base mode produces, including one that comes from a pointer fetch or from a top-of-stack access.

Top module: `opnd_addr_unit`

## Requirements
- R1: Codes 00000–00111 give `kind`=0 (register), `reg_sel` = low three code bits and `ea`=0, with `done` one cycle after `start` and no memory request.
- R2: Codes 01000–01111 give `kind`=1 (memory) and `ea` = `disp_a` + register[code[2:0]].
- R3: Codes 11000/11001/11010/11011 give `ea` = `disp_a` plus the frame pointer, stack pointer, static base or program counter, in that order.
- R4: Every stack-using mode uses `sp1_val` when `stk_sel`=1 and `sp0_val` when `stk_sel`=0.
- R5: Codes 10000/10001/10010 raise `mem_req` with `mem_addr` = `disp_a` + frame pointer, stack pointer or static base. `done` follows one cycle after the cycle in which `mem_ack` is seen, with `ea` = `mem_rdata` + `disp_b`.
- R6: Code 10110 reads the pointer at `link_base` + 4·`disp_a`, and `ea` = pointer + `disp_b`.
- R7: Code 10100 gives `kind`=2 (immediate) with `ea`=0. Code 10101 gives `kind`=1 with `ea` = `disp_a`.
- R8: Code 10111 uses the selected stack pointer. A write gives `ea` = `sp_new` = SP − size. A read gives `ea` = SP and `sp_new` = SP + size. `sp_upd` pulses with `done` and `sp_upd_sel` = `stk_sel`. The size is 1, 2, 4 or 8 bytes for `size_sel` 0–3.
- R9: Codes 11100–11111 add register[`idx_byte[2:0]`] × 1/2/4/8 (code[1:0] = 0..3) to the address of the base mode held in `idx_byte[7:4:3]` = `idx_byte[7:3]`.
- R10: Code 10011 gives `kind`=3 (illegal). An index byte whose base mode is register, immediate, reserved or scaled index also gives `kind`=3. An illegal result has `ea`=0, no memory request and no `sp_upd`.
- R11: While a pointer read is pending, `mem_req` and `mem_addr` stay stable until `mem_ack`, and `start` is ignored. This includes a `start` in the acknowledge cycle.
- R12: While `rst_n` is low, `done`, `mem_req` and `sp_upd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| mode_code | input | 5 | Operand mode field |
| disp_a | input | AW | First (or only) displacement |
| disp_b | input | AW | Second displacement for pointer modes |
| idx_byte | input | 8 | Index byte: [7:3] base mode, [2:0] index register |
| size_sel | input | 2 | Operand size, 1 << size_sel bytes |
| is_write | input | 1 | Operand is written (top-of-stack push) |
| stk_sel | input | 1 | Selects second stack pointer |
| gpr_vals | input | 8·AW | Eight general registers, register i at [i·AW +: AW] |
| fp_val | input | AW | Frame pointer |
| sp0_val | input | AW | Stack pointer 0 |
| sp1_val | input | AW | Stack pointer 1 |
| sb_val | input | AW | Static base |
| pc_val | input | AW | Program counter |
| link_base | input | AW | Link table base address |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | AW | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge |
| mem_rdata | input | AW | Pointer read data |
| done | output | 1 | Result valid pulse |
| kind | output | 2 | 0 register, 1 memory, 2 immediate, 3 illegal |
| ea | output | AW | Effective address |
| reg_sel | output | 3 | Register number for register kind |
| sp_upd | output | 1 | Stack pointer update valid |
| sp_upd_sel | output | 1 | Which stack pointer to update |
| sp_new | output | AW | New stack pointer value |

## Verification
Two functions can land on the same result cycle. Scaled index with a top-of-stack base must deliver the scaled address together with the stack pointer update. The bench issues that combination as a write and checks that `ea` carries the scaled offset on top of the decremented pointer, while `sp_new` carries only the decrement. A second collision is a new `start` presented in the very cycle that acknowledges a pending pointer read. The bench checks that the pointer result completes and that one cycle later neither `done` nor `mem_req` shows that the strobe was taken.

// File: rtl/opnd_addr_pkg.sv
// Shared types for the operand effective address generator.
// Assumes a 5-bit mode field and eight general registers.
package opnd_addr_pkg;

    typedef enum logic [3:0] {
        CLS_REG, CLS_REGREL, CLS_SPACE, CLS_MREL, CLS_IMM,
        CLS_ABS, CLS_EXT, CLS_TOS, CLS_INDEX, CLS_RSVD
    } mode_cls_e;

    typedef enum logic [1:0] {
        KIND_REG = 2'd0,
        KIND_MEM = 2'd1,
        KIND_IMM = 2'd2,
        KIND_BAD = 2'd3
    } ea_kind_e;

    typedef struct packed {
        mode_cls_e  cls;
        logic [2:0] sel;       // register number, base choice or scale
        logic       needs_ptr; // a pointer must be read from memory
    } mode_info_t;

endpackage

// File: rtl/opnd_mode_decode.sv
// Classifies a 5-bit operand mode code.
// Purely combinational; assumes nothing about the code value.
module opnd_mode_decode
    import opnd_addr_pkg::*;
(
    input  logic [4:0] code,
    output mode_info_t info
);

    // Map the code onto a class plus its selector bits.
    always_comb begin
        info.cls       = CLS_RSVD;
        info.sel       = code[2:0];
        info.needs_ptr = 1'b0;
        case (code[4:3])
            2'b00: info.cls = CLS_REG;
            2'b01: info.cls = CLS_REGREL;
            2'b11: begin
                info.sel = {1'b0, code[1:0]};
                info.cls = code[2] ? CLS_INDEX : CLS_SPACE;
            end
            default: begin
                case (code[2:0])
                    3'b000, 3'b001, 3'b010: begin
                        info.cls       = CLS_MREL;
                        info.needs_ptr = 1'b1;
                    end
                    3'b100: info.cls = CLS_IMM;
                    3'b101: info.cls = CLS_ABS;
                    3'b110: begin
                        info.cls       = CLS_EXT;
                        info.needs_ptr = 1'b1;
                    end
                    3'b111: info.cls = CLS_TOS;
                    default: info.cls = CLS_RSVD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/opnd_base_calc.sv
// Computes the first-step address of a (non-index) mode: either the final
// direct address or the address of a pointer to fetch, plus the stack
// pointer side effect of top-of-stack. Combinational.
// Assumes reg_val is the register chosen by info.sel and sp_cur the
// already selected stack pointer.
module opnd_base_calc
    import opnd_addr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINK_SHIFT = 2
) (
    input  mode_info_t    info,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] fp_val,
    input  logic [AW-1:0] sp_cur,
    input  logic [AW-1:0] sb_val,
    input  logic [AW-1:0] pc_val,
    input  logic [AW-1:0] link_base,
    input  logic [AW-1:0] disp_a,
    input  logic [AW-1:0] size_bytes,
    input  logic          is_write,
    output logic [AW-1:0] direct_addr,
    output logic [AW-1:0] ptr_addr,
    output logic [AW-1:0] sp_next,
    output logic          sp_touch
);

    logic [AW-1:0] space_base;

    // Choose the dedicated base register named by the low selector bits.
    always_comb begin
        case (info.sel[1:0])
            2'd0:    space_base = fp_val;
            2'd1:    space_base = sp_cur;
            2'd2:    space_base = sb_val;
            default: space_base = pc_val;
        endcase
    end

    // Form the address for each class.
    always_comb begin
        direct_addr = '0;
        ptr_addr    = '0;
        sp_next     = sp_cur;
        sp_touch    = 1'b0;
        case (info.cls)
            CLS_REGREL: direct_addr = reg_val + disp_a;
            CLS_SPACE:  direct_addr = space_base + disp_a;
            CLS_MREL:   ptr_addr    = space_base + disp_a;
            CLS_ABS:    direct_addr = disp_a;
            CLS_EXT:    ptr_addr    = link_base + (disp_a << LINK_SHIFT);
            CLS_TOS: begin
                sp_touch    = 1'b1;
                sp_next     = is_write ? sp_cur - size_bytes : sp_cur + size_bytes;
                direct_addr = is_write ? sp_cur - size_bytes : sp_cur;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opnd_addr_unit.sv
// Operand effective address generator, top level.
// Accepts a request on start while idle. Direct modes answer with done on
// the next cycle. Pointer modes first hold a read request until mem_ack and
// answer the cycle after. Assumes eight general registers packed in gpr_vals.
module opnd_addr_unit
    import opnd_addr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINK_SHIFT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [4:0]    mode_code,
    input  logic [AW-1:0] disp_a,
    input  logic [AW-1:0] disp_b,
    input  logic [7:0]    idx_byte,
    input  logic [1:0]    size_sel,
    input  logic          is_write,
    input  logic          stk_sel,
    input  logic [8*AW-1:0] gpr_vals,
    input  logic [AW-1:0] fp_val,
    input  logic [AW-1:0] sp0_val,
    input  logic [AW-1:0] sp1_val,
    input  logic [AW-1:0] sb_val,
    input  logic [AW-1:0] pc_val,
    input  logic [AW-1:0] link_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [1:0]    kind,
    output logic [AW-1:0] ea,
    output logic [2:0]    reg_sel,
    output logic          sp_upd,
    output logic          sp_upd_sel,
    output logic [AW-1:0] sp_new
);

    localparam int NREGS = 8;

    typedef enum logic {ST_IDLE, ST_FETCH} state_e;

    state_e        state;
    logic [AW-1:0] regs [NREGS];
    mode_info_t    info_m, info_i, info_e;
    logic          is_idx, idx_bad, bad;
    logic [AW-1:0] idx_off, sp_cur, size_bytes;
    logic [AW-1:0] direct_addr, ptr_addr, sp_next;
    logic          sp_touch;
    logic [AW-1:0] tail;

    // Unpack the flat register bus.
    for (genvar g = 0; g < NREGS; g++) begin : g_unpack
        assign regs[g] = gpr_vals[g*AW +: AW];
    end

    opnd_mode_decode i_dec_main (.code(mode_code),      .info(info_m));
    opnd_mode_decode i_dec_idx  (.code(idx_byte[7:3]),  .info(info_i));

    // Resolve the effective base mode and legality of the request.
    always_comb begin
        is_idx  = (info_m.cls == CLS_INDEX);
        info_e  = is_idx ? info_i : info_m;
        idx_bad = is_idx && (info_i.cls == CLS_INDEX || info_i.cls == CLS_IMM ||
                             info_i.cls == CLS_REG   || info_i.cls == CLS_RSVD);
        bad     = (info_m.cls == CLS_RSVD) || idx_bad;
        idx_off = is_idx ? (regs[idx_byte[2:0]] << info_m.sel[1:0]) : '0;
    end

    // Stack pointer choice and operand size in bytes.
    always_comb begin
        sp_cur     = stk_sel ? sp1_val : sp0_val;
        size_bytes = AW'(4'd1 << size_sel);
    end

    opnd_base_calc #(.AW(AW), .LINK_SHIFT(LINK_SHIFT)) i_base (
        .info        (info_e),
        .reg_val     (regs[info_e.sel]),
        .fp_val      (fp_val),
        .sp_cur      (sp_cur),
        .sb_val      (sb_val),
        .pc_val      (pc_val),
        .link_base   (link_base),
        .disp_a      (disp_a),
        .size_bytes  (size_bytes),
        .is_write    (is_write),
        .direct_addr (direct_addr),
        .ptr_addr    (ptr_addr),
        .sp_next     (sp_next),
        .sp_touch    (sp_touch)
    );

    // Request sequencing, pointer fetch and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mem_req    <= 1'b0;
            mem_addr   <= '0;
            tail       <= '0;
            done       <= 1'b0;
            kind       <= KIND_REG;
            ea         <= '0;
            reg_sel    <= '0;
            sp_upd     <= 1'b0;
            sp_upd_sel <= 1'b0;
            sp_new     <= '0;
        end else begin
            done   <= 1'b0;
            sp_upd <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (bad) begin
                            done    <= 1'b1;
                            kind    <= KIND_BAD;
                            ea      <= '0;
                            reg_sel <= '0;
                        end else if (info_e.needs_ptr) begin
                            mem_req  <= 1'b1;
                            mem_addr <= ptr_addr;
                            tail     <= disp_b + idx_off;
                            state    <= ST_FETCH;
                        end else begin
                            done    <= 1'b1;
                            reg_sel <= '0;
                            ea      <= '0;
                            case (info_e.cls)
                                CLS_REG: begin
                                    kind    <= KIND_REG;
                                    reg_sel <= info_e.sel;
                                end
                                CLS_IMM: kind <= KIND_IMM;
                                default: begin
                                    kind       <= KIND_MEM;
                                    ea         <= direct_addr + idx_off;
                                    sp_upd     <= sp_touch;
                                    sp_new     <= sp_next;
                                    sp_upd_sel <= stk_sel;
                                end
                            endcase
                        end
                    end
                end
                default: begin
                    if (mem_ack) begin
                        mem_req <= 1'b0;
                        done    <= 1'b1;
                        kind    <= KIND_MEM;
                        ea      <= mem_rdata + tail;
                        reg_sel <= '0;
                        state   <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/opnd_addr_chk.sv
// Protocol and result checks for opnd_addr_unit, attached by bind.
// Assumes the kind encoding of opnd_addr_pkg.
module opnd_addr_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic [1:0]    kind,
    input logic [AW-1:0] ea,
    input logic          sp_upd
);

    // R11: a pending read keeps its request and address until acknowledged.
    p_fetch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R5: an acknowledged read completes as a memory result next cycle.
    p_ack_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> done && kind == 2'd1 && !mem_req);

    // R1: a result is never presented while a read is outstanding.
    p_done_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R8: a stack pointer update only accompanies a memory result.
    p_sp_upd_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_upd |-> done && kind == 2'd1);

    // R10: an illegal result carries no address and no side effect.
    p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && kind == 2'd3 |-> !sp_upd && ea == '0);

    // R12: reset clears the strobes.
    p_reset_r12: assert property (@(posedge clk)
        !rst_n |=> !done && !mem_req && !sp_upd);

endmodule

bind opnd_addr_unit opnd_addr_chk #(.AW(AW)) i_opnd_addr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .done     (done),
    .kind     (kind),
    .ea       (ea),
    .sp_upd   (sp_upd)
);

// File: tb/test_opnd_addr_unit.sv
// Directed bench for opnd_addr_unit: one task per scenario.
module test_opnd_addr_unit;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    mode_code = '0;
    logic [AW-1:0] disp_a = '0, disp_b = '0;
    logic [7:0]    idx_byte = '0;
    logic [1:0]    size_sel = '0;
    logic          is_write = 1'b0, stk_sel = 1'b0;
    logic [8*AW-1:0] gpr_vals;
    logic [AW-1:0] fp_val = 32'h2000, sp0_val = 32'h3000, sp1_val = 32'h4000;
    logic [AW-1:0] sb_val = 32'h5000, pc_val = 32'h6000, link_base = 32'h7000;
    logic          mem_req, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr, mem_rdata = '0;
    logic          done, sp_upd, sp_upd_sel;
    logic [1:0]    kind;
    logic [AW-1:0] ea, sp_new;
    logic [2:0]    reg_sel;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    opnd_addr_unit #(.AW(AW)) i_opnd_addr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mode_code),
        .disp_a(disp_a), .disp_b(disp_b), .idx_byte(idx_byte),
        .size_sel(size_sel), .is_write(is_write), .stk_sel(stk_sel),
        .gpr_vals(gpr_vals), .fp_val(fp_val), .sp0_val(sp0_val),
        .sp1_val(sp1_val), .sb_val(sb_val), .pc_val(pc_val),
        .link_base(link_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .kind(kind),
        .ea(ea), .reg_sel(reg_sel), .sp_upd(sp_upd), .sp_upd_sel(sp_upd_sel),
        .sp_new(sp_new)
    );

    initial begin
        for (int i = 0; i < 8; i++) gpr_vals[i*AW +: AW] = 32'h1000_0000 + i * 32'h100;
    end

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [4:0] c, input logic [AW-1:0] da, input logic [AW-1:0] db,
                         input logic [7:0] ib, input logic [1:0] sz, input logic wr, input logic ss);
        mode_code = c; disp_a = da; disp_b = db; idx_byte = ib;
        size_sel = sz; is_write = wr; stk_sel = ss;
    endtask

    // Strobe start for one cycle; returns at the negedge after acceptance.
    task automatic pulse;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Acknowledge a pending read with the given data.
    task automatic ack(input logic [AW-1:0] data);
        mem_ack = 1'b1; mem_rdata = data;
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 done", done, 0);
        chk("R12 mem_req", mem_req, 0);
        chk("R12 sp_upd", sp_upd, 0);
    endtask

    task automatic t_register;
        setup(5'b00101, 32'h55, 0, 0, 0, 0, 0);
        pulse();
        chk("R1 done", done, 1);
        chk("R1 kind", kind, 0);
        chk("R1 reg_sel", reg_sel, 5);
        chk("R1 ea", ea, 0);
        chk("R1 no req", mem_req, 0);
        @(negedge clk);
        chk("R1 done single", done, 0);
    endtask

    task automatic t_regrel;
        setup(5'b01011, 32'hFFFF_FFF8, 0, 0, 0, 0, 0);
        pulse();
        chk("R2 kind", kind, 1);
        chk("R2 ea", ea, 32'h1000_02F8);
    endtask

    task automatic t_space;
        setup(5'b11000, 32'h10, 0, 0, 0, 0, 0); pulse();
        chk("R3 frame", ea, 32'h2010);
        setup(5'b11001, 32'h10, 0, 0, 0, 0, 0); pulse();
        chk("R3 stack", ea, 32'h3010);
        setup(5'b11010, 32'h10, 0, 0, 0, 0, 0); pulse();
        chk("R3 static", ea, 32'h5010);
        setup(5'b11011, 32'h10, 0, 0, 0, 0, 0); pulse();
        chk("R3 program", ea, 32'h6010);
        setup(5'b11001, 32'h10, 0, 0, 0, 0, 1); pulse();
        chk("R4 stack sel1", ea, 32'h4010);
    endtask

    task automatic t_memrel;
        setup(5'b10001, 32'h4, 32'hC, 0, 0, 0, 1);
        pulse();
        chk("R5 req", mem_req, 1);
        chk("R5/R4 addr", mem_addr, 32'h4004);
        chk("R5 no done", done, 0);
        // R11: a new start while waiting is ignored and the request holds
        setup(5'b10101, 32'h999, 0, 0, 0, 0, 0);
        pulse();
        chk("R11 req held", mem_req, 1);
        chk("R11 addr held", mem_addr, 32'h4004);
        chk("R11 no done", done, 0);
        ack(32'h8000);
        chk("R5 done", done, 1);
        chk("R5 kind", kind, 1);
        chk("R5 ea", ea, 32'h800C);
        chk("R5 req drop", mem_req, 0);
    endtask

    task automatic t_external;
        setup(5'b10110, 32'h3, 32'h2, 0, 0, 0, 0);
        pulse();
        chk("R6 addr", mem_addr, 32'h700C);
        // R11: start arriving together with the acknowledge is ignored
        setup(5'b10101, 32'h777, 0, 0, 0, 0, 0);
        start = 1'b1;
        ack(32'h9000);
        start = 1'b0;
        chk("R6 ea", ea, 32'h9002);
        chk("R6 done", done, 1);
        @(negedge clk);
        chk("R11 ack-cycle start dropped", done, 0);
        chk("R11 no new req", mem_req, 0);
    endtask

    task automatic t_imm_abs;
        setup(5'b10100, 32'h1, 0, 0, 0, 0, 0); pulse();
        chk("R7 imm kind", kind, 2);
        chk("R7 imm ea", ea, 0);
        setup(5'b10101, 32'h1234, 0, 0, 0, 0, 0); pulse();
        chk("R7 abs kind", kind, 1);
        chk("R7 abs ea", ea, 32'h1234);
    endtask

    task automatic t_tos;
        setup(5'b10111, 0, 0, 0, 2'd2, 1, 1); pulse();
        chk("R8 push ea", ea, 32'h3FFC);
        chk("R8 push sp_new", sp_new, 32'h3FFC);
        chk("R8 push upd", sp_upd, 1);
        chk("R8 push sel", sp_upd_sel, 1);
        setup(5'b10111, 0, 0, 0, 2'd3, 0, 0); pulse();
        chk("R8 pop ea", ea, 32'h3000);
        chk("R8 pop sp_new", sp_new, 32'h3008);
        chk("R8 pop sel", sp_upd_sel, 0);
        @(negedge clk);
        chk("R8 upd single", sp_upd, 0);
    endtask

    task automatic t_index;
        setup(5'b11110, 32'h10, 0, 8'hD2, 0, 0, 0); pulse();
        chk("R9 static x4", ea, 32'h4000_5810);
        chk("R9 no upd", sp_upd, 0);
        setup(5'b11111, 32'h20, 32'h4, 8'h81, 0, 0, 0); pulse();
        chk("R9 ptr addr", mem_addr, 32'h2020);
        ack(32'hA000);
        chk("R9 ptr x8", ea, 32'h8000_A804);
        // index over top-of-stack push: scaled address and SP update together
        setup(5'b11101, 0, 0, 8'hB8, 2'd1, 1, 0); pulse();
        chk("R9 tos x2 ea", ea, 32'h2000_2FFE);
        chk("R8 tos idx sp_new", sp_new, 32'h2FFE);
        chk("R8 tos idx upd", sp_upd, 1);
    endtask

    task automatic t_illegal;
        setup(5'b10011, 32'h10, 0, 0, 0, 0, 0); pulse();
        chk("R10 rsvd kind", kind, 3);
        chk("R10 rsvd ea", ea, 0);
        chk("R10 rsvd no req", mem_req, 0);
        setup(5'b11100, 0, 0, 8'hE8, 0, 0, 0); pulse();
        chk("R10 idx of idx", kind, 3);
        setup(5'b11100, 0, 0, 8'hA0, 0, 0, 0); pulse();
        chk("R10 idx of imm", kind, 3);
        setup(5'b11100, 0, 0, 8'h10, 0, 0, 0); pulse();
        chk("R10 idx of reg", kind, 3);
        setup(5'b11100, 0, 0, 8'h98, 0, 1, 0); pulse();
        chk("R10 idx of rsvd", kind, 3);
        chk("R10 no upd", sp_upd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_register();
        t_regrel();
        t_space();
        t_memrel();
        t_external();
        t_imm_abs();
        t_tos();
        t_index();
        t_illegal();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule